// File: doc/BRIEF.md
# Pin Controller with Interrupt Sensing

A 32-pin general-purpose I/O controller with a memory-mapped interface. Software reaches it through 32-bit word registers. Each pin works in one of three ways: as a plain input, as a driven output, or as an interrupt source. An interrupt source senses either a level or an edge, and a per-pin inversion bit selects active-high/rising or active-low/falling.

Pin inputs pass through a two-flop synchroniser before they are used. Interrupt events latch into a per-pin pending vector, and software clears it by writing ones. A line is enabled either by loading the enable register directly or by OR-ing ones into it through a separate set address. All enabled pending bits are OR-ed into a single interrupt output.

Register accesses are plain single-cycle strobes with no back-pressure. A write takes effect at the clock edge on which `bus_wr` is sampled high. Read data is combinational from `bus_addr`.

Top module: `gpio_ctl_top`

## Requirements
- R1: After reset, all configuration, pending and enable state is zero, `pin_oe` is zero and `irq_o` is low.
- R2: `pin_oe[i]` is 1 exactly when the direction bit is 1 and the interrupt-mode bit is 0. `pin_out` always shows the output register, so a value loaded earlier is driven as soon as the pin becomes an output.
- R3: Reading the input register at byte address 0x0C returns the synchronised pin levels XOR the inversion register. A pin change is visible two clocks after it is sampled.
- R4: A pin whose interrupt-mode bit (byte 0x00, 1 = interrupt) is 0 never sets its pending bit.
- R5: Writing to the clear address (byte 0x14) clears the pending bits written as 1 and keeps the bits written as 0. A trigger active in the same cycle wins over the clear.
- R6: Writing to the enable-set address (byte 0x1C) ORs ones into the enable register. Bits written as 0 change nothing.
- R7: With the edge-select bit set (byte 0x24, 1 = edge), a pending bit is set once on each inactive-to-active transition of the pin after inversion. Holding the pin active does not set the bit again after a clear, and the opposite transition sets nothing.
- R8: A write to byte 0x18 loads the enable register directly, with 1 meaning enabled. `irq_o` is the OR of pending AND enable (pending is read at byte 0x10).
- R9: The inversion register sits at byte 0x20 (1 = active-low/falling). Writes to the pending address are ignored. The clear and enable-set addresses read as 0. The filter register at byte 0x28 is storage only and reads back what was written. Direction is at 0x04 (1 = output) and output data at 0x08.
- R10: In level mode (edge-select 0), a pending bit is set on every cycle its condition is active, including the cycle right after a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 6 | Byte address; bits [1:0] must be 0 for a hit |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output values to the pads |
| pin_oe | output | 32 | Per-pin drive enable |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench clears a level-sensitive pin while its condition is still present. A design that let the clear win would show the bit as 0, when it should be set again at once. It clears an edge-sensitive pin that is held active; a design that re-armed on the level would set the bit again. It also drives the opposite edge, which a both-edge detector would wrongly latch. Write-one semantics are checked with all-zero writes to the clear and enable-set addresses, which a design that loads those registers would turn into wipes. Pins in plain input mode are held at an active level, and a missing mode gate would show up as pending bits.

// File: rtl/gpio_ctl_pkg.sv
package gpio_ctl_pkg;
  localparam int unsigned SEL_W = 4;

  // word index of each register (byte address >> 2)
  typedef enum logic [SEL_W-1:0] {
    SEL_MODE   = 4'h0,
    SEL_DIR    = 4'h1,
    SEL_OUT    = 4'h2,
    SEL_IN     = 4'h3,
    SEL_PEND   = 4'h4,
    SEL_CLR    = 4'h5,
    SEL_ENA    = 4'h6,
    SEL_ENASET = 4'h7,
    SEL_INV    = 4'h8,
    SEL_EDGE   = 4'h9,
    SEL_FILT   = 4'hA
  } reg_sel_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= '0;
        else        chain_q[s] <= async_in;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= '0;
        else        chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_ctl_pkg::*;
#(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [NPINS-1:0]  mode_q,
  output logic [NPINS-1:0]  dir_q,
  output logic [NPINS-1:0]  out_q,
  output logic [NPINS-1:0]  ena_q,
  output logic [NPINS-1:0]  inv_q,
  output logic [NPINS-1:0]  edge_q,
  output logic [NPINS-1:0]  filt_q,
  output logic [NPINS-1:0]  clr_vec
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic             hit;
  logic [IDX_W-1:0] idx;
  logic [NPINS-1:0] wd;

  assign hit = bus_wr && (bus_addr[1:0] == 2'b00);
  assign idx = bus_addr[ADDR_W-1:2];
  assign wd  = bus_wdata[NPINS-1:0];

  function automatic logic is_sel(input logic [IDX_W-1:0] i, input reg_sel_e s);
    return i == IDX_W'(s);
  endfunction

  // write-one pulse towards the pending logic
  assign clr_vec = (hit && is_sel(idx, SEL_CLR)) ? wd : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      dir_q  <= '0;
      out_q  <= '0;
      ena_q  <= '0;
      inv_q  <= '0;
      edge_q <= '0;
      filt_q <= '0;
    end else if (hit) begin
      if (is_sel(idx, SEL_MODE))   mode_q <= wd;
      if (is_sel(idx, SEL_DIR))    dir_q  <= wd;
      if (is_sel(idx, SEL_OUT))    out_q  <= wd;
      if (is_sel(idx, SEL_ENA))    ena_q  <= wd;
      if (is_sel(idx, SEL_ENASET)) ena_q  <= ena_q | wd;
      if (is_sel(idx, SEL_INV))    inv_q  <= wd;
      if (is_sel(idx, SEL_EDGE))   edge_q <= wd;
      if (is_sel(idx, SEL_FILT))   filt_q <= wd;
    end
  end
endmodule

// File: rtl/gpio_irq_core.sv
module gpio_irq_core #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] sync_lvl,
  input  logic [NPINS-1:0] mode_q,
  input  logic [NPINS-1:0] inv_q,
  input  logic [NPINS-1:0] edge_q,
  input  logic [NPINS-1:0] clr_vec,
  output logic [NPINS-1:0] cur_lvl,
  output logic [NPINS-1:0] rise_vec,
  output logic [NPINS-1:0] pend_q
);
  logic [NPINS-1:0] prev_q;
  logic [NPINS-1:0] trig;

  assign cur_lvl = sync_lvl ^ inv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cur_lvl;
  end

  assign rise_vec = cur_lvl & ~prev_q;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    always_comb begin
      if (!mode_q[i])     trig[i] = 1'b0;
      else if (edge_q[i]) trig[i] = rise_vec[i];
      else                trig[i] = cur_lvl[i];
    end
  end

  // a trigger in the same cycle wins over a clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_vec) | trig;
  end
endmodule

// File: rtl/gpio_ctl_top.sv
module gpio_ctl_top
  import gpio_ctl_pkg::*;
#(
  parameter int unsigned NPINS       = 32,
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [NPINS-1:0] mode_q, dir_q, out_q, ena_q, inv_q, edge_q, filt_q;
  logic [NPINS-1:0] clr_vec, sync_lvl, cur_lvl, rise_vec, pend_q;

  gpio_cfg_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .mode_q(mode_q), .dir_q(dir_q), .out_q(out_q),
    .ena_q(ena_q), .inv_q(inv_q), .edge_q(edge_q), .filt_q(filt_q),
    .clr_vec(clr_vec)
  );

  gpio_in_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(sync_lvl)
  );

  gpio_irq_core #(.NPINS(NPINS)) u_irq (
    .clk(clk), .rst_n(rst_n), .sync_lvl(sync_lvl), .mode_q(mode_q),
    .inv_q(inv_q), .edge_q(edge_q), .clr_vec(clr_vec), .cur_lvl(cur_lvl),
    .rise_vec(rise_vec), .pend_q(pend_q)
  );

  assign pin_out = out_q;
  assign pin_oe  = dir_q & ~mode_q;
  assign irq_o   = |(pend_q & ena_q);

  function automatic logic [31:0] widen(input logic [NPINS-1:0] v);
    logic [31:0] r;
    r = '0;
    r[NPINS-1:0] = v;
    return r;
  endfunction

  logic [IDX_W-1:0] rd_idx;
  assign rd_idx = bus_addr[ADDR_W-1:2];

  always_comb begin
    bus_rdata = '0;
    if (bus_addr[1:0] == 2'b00) begin
      case (rd_idx)
        IDX_W'(SEL_MODE): bus_rdata = widen(mode_q);
        IDX_W'(SEL_DIR):  bus_rdata = widen(dir_q);
        IDX_W'(SEL_OUT):  bus_rdata = widen(out_q);
        IDX_W'(SEL_IN):   bus_rdata = widen(cur_lvl);
        IDX_W'(SEL_PEND): bus_rdata = widen(pend_q);
        IDX_W'(SEL_ENA):  bus_rdata = widen(ena_q);
        IDX_W'(SEL_INV):  bus_rdata = widen(inv_q);
        IDX_W'(SEL_EDGE): bus_rdata = widen(edge_q);
        IDX_W'(SEL_FILT): bus_rdata = widen(filt_q);
        default:          bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_ctl_checker.sv
module gpio_ctl_checker #(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [NPINS-1:0]  pin_oe,
  input logic              irq_o,
  input logic [NPINS-1:0]  mode_q,
  input logic [NPINS-1:0]  edge_q,
  input logic [NPINS-1:0]  ena_q,
  input logic [NPINS-1:0]  pend_q,
  input logic [NPINS-1:0]  cur_lvl,
  input logic [NPINS-1:0]  rise_vec
);
  logic wr_clr, wr_set;
  assign wr_clr = bus_wr && (bus_addr == ADDR_W'(8'h14));
  assign wr_set = bus_wr && (bus_addr == ADDR_W'(8'h1C));

  AST_OE_NOT_IRQ_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & mode_q) == '0); // R2

  AST_NO_PEND_IN_GPIO: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(mode_q)) == '0)); // R4

  AST_EDGE_CLEAR_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((pend_q & $past(bus_wdata[NPINS-1:0]) & $past(edge_q)
                 & ~$past(rise_vec)) == '0)); // R5

  AST_ENASET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((ena_q & $past(ena_q)) == $past(ena_q))); // R6

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> (ena_q != '0)); // R8

  AST_LEVEL_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(mode_q & ~edge_q & cur_lvl) & ~pend_q) == '0)); // R10
endmodule

bind gpio_ctl_top gpio_ctl_checker #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .pin_oe(pin_oe), .irq_o(irq_o), .mode_q(mode_q),
  .edge_q(edge_q), .ena_q(ena_q), .pend_q(pend_q), .cur_lvl(cur_lvl),
  .rise_vec(rise_vec)
);

// File: tb/gpio_ctl_top_tb_top.sv
module gpio_ctl_top_tb_top;
  localparam int CLK_PERIOD = 10;

  localparam logic [5:0] A_MODE = 6'h00, A_DIR = 6'h04, A_OUT = 6'h08,
    A_IN = 6'h0C, A_PEND = 6'h10, A_CLR = 6'h14, A_ENA = 6'h18,
    A_ENASET = 6'h1C, A_INV = 6'h20, A_EDGE = 6'h24, A_FILT = 6'h28;

  typedef enum int {K_RD, K_IRQ, K_OE, K_OUT} kind_e;
  typedef struct {
    kind_e       kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic        irq_o;

  item_t sb_q[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_ctl_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_o(irq_o)
  );

  // monitor: compares one queued item per cycle, away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb_q.pop_front();
        case (it.kind)
          K_RD:    act = bus_rdata;
          K_IRQ:   act = {31'b0, irq_o};
          K_OE:    act = pin_oe;
          default: act = pin_out;
        endcase
        n_cmp++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic chk(input kind_e k, input logic [5:0] a, input logic [31:0] e,
                     input string tag);
    item_t it;
    @(posedge clk); #1;
    bus_addr = a;
    it.kind = k; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic drive_pins(input logic [31:0] v);
    @(posedge clk); #1;
    pin_in = v;
    repeat (4) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    chk(K_RD, A_ENA, 32'h0, "R1 enable");
    chk(K_RD, A_PEND, 32'h0, "R1 pending");
    chk(K_RD, A_MODE, 32'h0, "R1 mode");
    chk(K_OE, A_MODE, 32'h0, "R1 pin_oe");
    chk(K_IRQ, A_MODE, 32'h0, "R1 irq");

    // R2 output path
    wr(A_OUT, 32'hA5A5_0000);
    chk(K_OUT, A_MODE, 32'hA5A5_0000, "R2 preloaded out");
    chk(K_OE, A_MODE, 32'h0, "R2 oe before dir");
    wr(A_DIR, 32'hFFFF_0000);
    chk(K_OE, A_MODE, 32'hFFFF_0000, "R2 oe after dir");
    wr(A_MODE, 32'h0001_0000);
    chk(K_OE, A_MODE, 32'hFFFE_0000, "R2 irq pin not driven");
    chk(K_RD, A_DIR, 32'hFFFF_0000, "R9 dir readback");
    wr(A_MODE, 32'h0);
    wr(A_DIR, 32'h0);

    // R3 input, R4 no pending in plain mode
    drive_pins(32'h1234_5678);
    chk(K_RD, A_IN, 32'h1234_5678, "R3 input levels");
    wr(A_INV, 32'h0000_000F);
    chk(K_RD, A_IN, 32'h1234_5677, "R3 inverted input");
    chk(K_RD, A_PEND, 32'h0, "R4 plain pins no pending");
    wr(A_INV, 32'h0);
    drive_pins(32'h0);

    // R10 level high on pin 0, R8/R6 enable
    wr(A_MODE, 32'h1);
    drive_pins(32'h1);
    chk(K_RD, A_PEND, 32'h1, "R10 level high pending");
    chk(K_IRQ, A_MODE, 32'h0, "R8 masked no irq");
    wr(A_ENASET, 32'h1);
    chk(K_IRQ, A_MODE, 32'h1, "R6 enable-set raises irq");
    chk(K_RD, A_ENA, 32'h1, "R6 enable value");
    wr(A_CLR, 32'h1);
    chk(K_RD, A_PEND, 32'h1, "R10 level re-sets after clear");
    drive_pins(32'h0);
    wr(A_CLR, 32'h1);
    chk(K_RD, A_PEND, 32'h0, "R5 clear once inactive");
    chk(K_IRQ, A_MODE, 32'h0, "R8 irq drops");

    // level low on pin 1
    wr(A_INV, 32'h2);
    wr(A_MODE, 32'h3);
    chk(K_RD, A_PEND, 32'h2, "R10 level low pending");
    drive_pins(32'h2);
    wr(A_CLR, 32'h2);
    chk(K_RD, A_PEND, 32'h0, "R5 level low cleared");

    // R7 rising edge on pin 2
    wr(A_EDGE, 32'h4);
    wr(A_MODE, 32'h7);
    drive_pins(32'h6);
    chk(K_RD, A_PEND, 32'h4, "R7 rising edge pending");
    wr(A_CLR, 32'h4);
    repeat (3) @(posedge clk);
    chk(K_RD, A_PEND, 32'h0, "R7 held high no re-set");
    drive_pins(32'h2);
    chk(K_RD, A_PEND, 32'h0, "R7 falling ignored on rising pin");

    // R7 falling edge on pin 3
    wr(A_INV, 32'hA);
    wr(A_EDGE, 32'hC);
    wr(A_MODE, 32'hF);
    drive_pins(32'hA);
    chk(K_RD, A_PEND, 32'h0, "R7 rise ignored on falling pin");
    drive_pins(32'h2);
    chk(K_RD, A_PEND, 32'h8, "R7 falling edge pending");
    wr(A_ENASET, 32'h8);
    chk(K_RD, A_ENA, 32'h9, "R6 enable-set ORs");
    chk(K_IRQ, A_MODE, 32'h1, "R8 irq from pin 3");

    // zero writes, direct load, read-only and storage
    wr(A_CLR, 32'h0);
    chk(K_RD, A_PEND, 32'h8, "R5 zero clear no effect");
    wr(A_ENASET, 32'h0);
    chk(K_RD, A_ENA, 32'h9, "R6 zero set no effect");
    wr(A_ENA, 32'h1);
    chk(K_RD, A_ENA, 32'h1, "R8 direct load");
    chk(K_IRQ, A_MODE, 32'h0, "R8 pending masked off");
    wr(A_PEND, 32'hFFFF_FFFF);
    chk(K_RD, A_PEND, 32'h8, "R9 pending not writable");
    wr(A_FILT, 32'h5A5A);
    chk(K_RD, A_FILT, 32'h5A5A, "R9 filter storage");
    chk(K_RD, A_CLR, 32'h0, "R9 clear reads zero");
    chk(K_RD, A_ENASET, 32'h0, "R9 enable-set reads zero");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule